// File: doc/BRIEF.md
# Single-Wire Synchronized Byte Transmitter

This block sends a packet of fixed-width chunks over one shared data line. Each chunk is framed the same way. First comes a sync pulse: the line is driven low for one bit period and then high for one bit period. Next come the chunk's data bits, most-significant first. Last comes a parity bit that makes the count of ones even. After the parity bit the line is held low, so that the next sync, or whatever handshake follows, starts with a clean rising edge.

Chunks are taken one at a time from a valid/ready stream. The packet length is taken from `count_i` when the first chunk of a packet is accepted. The chunk width is taken from `width_i` with each chunk: 8 bits is the usual width for payload and 7 bits for an identifier chunk. The bit period is a parameter counted in clock cycles, and the receiver must use the same value. Direction turnaround and line arbitration are handled elsewhere. The block only reports that the line is driven (`oe_o`) and, with a one-cycle `done_o`, that the packet has finished.

Top module: `sync_line_tx`

## Requirements
- R1: After reset, and whenever no packet is in progress, `oe_o`=0, `line_o`=1, `ready_o`=1 and `done_o`=0.
- R2: In the cycle after a chunk is accepted (`valid_i`&&`ready_o` at a clock edge), the sync pulse begins: `line_o` is 0 for BIT_CYCLES cycles and then 1 for BIT_CYCLES cycles, with `oe_o`=1.
- R3: After the sync pulse, data bits `data_i[w-1]` down to `data_i[0]` are driven in that order, each for BIT_CYCLES cycles. Bits of `data_i` at position w or above have no effect on the line.
- R4: After the last data bit, a parity bit is driven for BIT_CYCLES cycles. It is 1 exactly when the w transmitted bits contain an odd number of ones.
- R5: Once the parity bit ends, `line_o`=0 and `oe_o`=1, and they stay that way for as long as the block waits for the next chunk of the packet, however long that wait is.
- R6: `ready_o` is 0 from the cycle after an acceptance until the parity bit of that chunk has ended. Between chunks of a packet it is 1.
- R7: A packet contains `count_i` chunks, sampled when its first chunk is accepted; a count of 0 is treated as 1. After the last parity bit, `done_o` is 1 for exactly one cycle, with `line_o`=0 and `oe_o`=1, and the block then returns to the R1 state.
- R8: The chunk width w is sampled from `width_i` at each acceptance. Valid widths are 1 to MAX_WIDTH; a value of 0 or a value above MAX_WIDTH selects MAX_WIDTH.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | MAX_WIDTH | Chunk to send, right-aligned |
| valid_i | input | 1 | Chunk on `data_i` is valid |
| ready_o | output | 1 | Block can accept a chunk |
| width_i | input | $clog2(MAX_WIDTH+1) | Chunk width in bits |
| count_i | input | CNT_W | Chunks in the packet, sampled at the first chunk |
| line_o | output | 1 | Level driven onto the shared line |
| oe_o | output | 1 | Line driver enable |
| done_o | output | 1 | One-cycle pulse after the packet's last parity bit |

## Verification
The hardest case to reach from the ports is the wait between two chunks of one packet. The line has to stay low and driven while the stream source withholds `valid_i`, and this state only exists in the middle of a multi-chunk packet. The bench reaches it by starting a three-chunk packet and holding back the second chunk for several cycles, checking the line in every cycle of the wait. It also sends a 7-bit chunk whose unused top input bit is set, to show that bits above the width reach neither the data bits nor the parity bit.

// File: rtl/sync_line_tx_pkg.sv
package sync_line_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SYNC_LO,
    ST_SYNC_HI,
    ST_DATA,
    ST_PAR,
    ST_GAP,
    ST_DONE
  } tx_state_e;
endpackage

// File: rtl/slt_bit_timer.sv
module slt_bit_timer #(
  parameter int unsigned BIT_CYCLES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned CW = (BIT_CYCLES > 1) ? $clog2(BIT_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(BIT_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!en_i || tick_o)   cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/slt_parity.sv
module slt_parity #(
  parameter int unsigned MAX_WIDTH = 8,
  localparam int unsigned WID_W = $clog2(MAX_WIDTH + 1)
) (
  input  logic [MAX_WIDTH-1:0] data_i,
  input  logic [WID_W-1:0]     width_i,
  output logic                 par_o
);
  // odd count of ones among the low width_i bits -> 1
  always_comb begin
    par_o = 1'b0;
    for (int i = 0; i < MAX_WIDTH; i++) begin
      if (WID_W'(i) < width_i) par_o = par_o ^ data_i[i];
    end
  end
endmodule

// File: rtl/sync_line_tx.sv
module sync_line_tx
  import sync_line_tx_pkg::*;
#(
  parameter int unsigned BIT_CYCLES = 4,
  parameter int unsigned MAX_WIDTH  = 8,
  parameter int unsigned CNT_W      = 8,
  localparam int unsigned WID_W = $clog2(MAX_WIDTH + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [MAX_WIDTH-1:0] data_i,
  input  logic                 valid_i,
  output logic                 ready_o,
  input  logic [WID_W-1:0]     width_i,
  input  logic [CNT_W-1:0]     count_i,
  output logic                 line_o,
  output logic                 oe_o,
  output logic                 done_o
);
  localparam logic [WID_W-1:0] WMAX = WID_W'(MAX_WIDTH);

  tx_state_e            state_q;
  logic [MAX_WIDTH-1:0] sh_q;
  logic                 par_q;
  logic [WID_W-1:0]     idx_q;
  logic [CNT_W-1:0]     rem_q;
  logic [WID_W-1:0]     eff_w;
  logic                 par_w;
  logic                 tick;
  logic                 timed;
  logic                 accept;

  assign eff_w  = (width_i == '0 || width_i > WMAX) ? WMAX : width_i;
  assign accept = valid_i && ready_o;
  assign timed  = (state_q == ST_SYNC_LO) || (state_q == ST_SYNC_HI) ||
                  (state_q == ST_DATA) || (state_q == ST_PAR);

  slt_parity #(.MAX_WIDTH(MAX_WIDTH)) i_parity (
    .data_i (data_i),
    .width_i(eff_w),
    .par_o  (par_w)
  );

  slt_bit_timer #(.BIT_CYCLES(BIT_CYCLES)) i_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (timed),
    .tick_o(tick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sh_q    <= '0;
      par_q   <= 1'b0;
      idx_q   <= '0;
      rem_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE, ST_GAP: if (accept) begin
          sh_q    <= data_i;
          par_q   <= par_w;
          idx_q   <= eff_w - 1'b1;
          state_q <= ST_SYNC_LO;
          if (state_q == ST_IDLE)
            rem_q <= (count_i == '0) ? CNT_W'(1) : count_i;
        end
        ST_SYNC_LO: if (tick) state_q <= ST_SYNC_HI;
        ST_SYNC_HI: if (tick) state_q <= ST_DATA;
        ST_DATA: if (tick) begin
          if (idx_q == '0) state_q <= ST_PAR;
          else             idx_q   <= idx_q - 1'b1;
        end
        ST_PAR: if (tick) begin
          rem_q   <= rem_q - 1'b1;
          state_q <= (rem_q == CNT_W'(1)) ? ST_DONE : ST_GAP;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (state_q)
      ST_IDLE:    line_o = 1'b1;
      ST_SYNC_LO: line_o = 1'b0;
      ST_SYNC_HI: line_o = 1'b1;
      ST_DATA:    line_o = sh_q[idx_q];
      ST_PAR:     line_o = par_q;
      default:    line_o = 1'b0; // gap / done: leave low for next rising edge
    endcase
  end

  assign oe_o    = (state_q != ST_IDLE);
  assign ready_o = (state_q == ST_IDLE) || (state_q == ST_GAP);
  assign done_o  = (state_q == ST_DONE);
endmodule

// File: rtl/sync_line_tx_chk.sv
module sync_line_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic valid_i,
  input logic ready_o,
  input logic line_o,
  input logic oe_o,
  input logic done_o
);
  assert_released_high_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_o |-> line_o && ready_o && !done_o);

  assert_accept_sync_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o) |=> oe_o && !line_o && !ready_o);

  assert_gap_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && oe_o) |-> !line_o);

  assert_gap_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && oe_o && !valid_i) |=> ready_o && oe_o);

  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !oe_o);

  assert_done_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> oe_o && !line_o && !ready_o);
endmodule

bind sync_line_tx sync_line_tx_chk i_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .valid_i(valid_i),
  .ready_o(ready_o),
  .line_o (line_o),
  .oe_o   (oe_o),
  .done_o (done_o)
);

// File: tb/test_sync_line_tx.sv
module test_sync_line_tx;
  localparam int BITC = 4;
  localparam int MW   = 8;
  localparam int WW   = $clog2(MW + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [MW-1:0] data = '0;
  logic          valid = 1'b0;
  logic [WW-1:0] width = WW'(8);
  logic [7:0]    count = 8'd1;
  logic          ready, line, oe, done;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  sync_line_tx #(.BIT_CYCLES(BITC), .MAX_WIDTH(MW), .CNT_W(8)) i_sync_line_tx (
    .clk_i(clk), .rst_ni(rst_n), .data_i(data), .valid_i(valid), .ready_o(ready),
    .width_i(width), .count_i(count), .line_o(line), .oe_o(oe), .done_o(done)
  );

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic check_idle(input string req);
    chk(req, {oe, line, ready, done}, 4'b0110);
  endtask

  // send one chunk of width w (effective), after wait_c cycles of holding valid low
  task automatic send_chunk(input logic [MW-1:0] d, input int w_in, input int w_eff,
                            input bit last, input int wait_c, input bit in_gap);
    logic [63:0] exp_line;
    int n;
    int bad;
    int p;
    for (int k = 0; k < wait_c; k++) begin
      if (in_gap) chk("R5 gap hold", {oe, line, ready, done}, 4'b1010);
      else        check_idle("R1 idle wait");
      @(negedge clk);
    end
    data  = d;
    width = WW'(w_in);
    valid = 1'b1;
    chk("R6 ready before accept", {3'b0, ready}, 4'b0001);
    @(posedge clk);
    @(negedge clk);
    valid = 1'b0;
    data  = ~d;
    p = 0;
    for (int b = 0; b < w_eff; b++) p ^= d[b];
    n = 0;
    for (int k = 0; k < BITC; k++) begin exp_line[n] = 1'b0; n++; end
    for (int k = 0; k < BITC; k++) begin exp_line[n] = 1'b1; n++; end
    for (int b = w_eff - 1; b >= 0; b--)
      for (int k = 0; k < BITC; k++) begin exp_line[n] = d[b]; n++; end
    for (int k = 0; k < BITC; k++) begin exp_line[n] = p[0]; n++; end
    bad = 0;
    for (int c = 0; c < n; c++) begin
      if (line !== exp_line[c] || oe !== 1'b1 || ready !== 1'b0 || done !== 1'b0) begin
        if (bad == 0)
          $display("FAIL R2/R3/R4/R6 frame cycle %0d actual line=%b oe=%b rdy=%b expected line=%b oe=1 rdy=0",
                   c, line, oe, ready, exp_line[c]);
        bad++;
      end
      @(negedge clk);
    end
    checks++;
    if (bad != 0) errors++;
    if (last) begin
      chk("R7 done pulse line low", {oe, line, ready, done}, 4'b1001);
      @(negedge clk);
      check_idle("R7 back to idle");
    end else begin
      chk("R5 low after parity", {oe, line, ready, done}, 4'b1010);
    end
  endtask

  task automatic t_reset;
    check_idle("R1 reset");
  endtask

  task automatic t_single;
    count = 8'd1;
    send_chunk(8'hA5, 8, 8, 1'b1, 2, 1'b0);
  endtask

  task automatic t_multi_gap;
    count = 8'd3;
    send_chunk(8'h01, 8, 8, 1'b0, 1, 1'b0);
    count = 8'd1; // must not shorten the packet (R7)
    send_chunk(8'hFF, 8, 8, 1'b0, 5, 1'b1);
    send_chunk(8'h80, 8, 8, 1'b1, 0, 1'b1);
  endtask

  task automatic t_width7;
    count = 8'd2;
    // bit 7 set but outside a 7-bit chunk (R3, R8)
    send_chunk(8'hD3, 7, 7, 1'b0, 1, 1'b0);
    send_chunk(8'h80 | 8'h07, 7, 7, 1'b1, 0, 1'b1);
  endtask

  task automatic t_zero_count;
    count = 8'd0;
    send_chunk(8'h3C, 8, 8, 1'b1, 1, 1'b0);
  endtask

  task automatic t_width_clamp;
    count = 8'd1;
    send_chunk(8'h6B, 0, 8, 1'b1, 1, 1'b0);
    count = 8'd1;
    send_chunk(8'h01, 3, 3, 1'b1, 1, 1'b0);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_multi_gap();
    t_width7();
    t_zero_count();
    t_width_clamp();
    repeat (2) @(negedge clk);
    check_idle("R1 final idle");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule